// File: doc/BRIEF.md
# 24-bit three-wire serial register master

This block is a serial host for reaching the 16-bit registers of a display bridge over a three-wire link. The link has an active-low chip select, a clock and a data-out line, plus an optional data-in line. A requester hands it one register access at a time on a valid/ready command port. For a write it gives an 8-bit register number and a 16-bit value; for a read it gives only the register number. The block turns each access into two 24-bit frames. Writes finish with a one-cycle done pulse. Reads finish with a one-cycle response-valid pulse that carries the captured 16-bit value.

Bit timing is set by the parameter `BIT_CLKS`, the number of system clocks in one bit-delay. The chip-select guard delay is twice that. The parameter `HAS_MISO` says whether the data-in pin is wired. A single state machine sequences the transfer:

- **ST_IDLE**: all pins high, ready asserted. A valid request moves it to ST_CS_SETUP.
- **ST_CS_SETUP**: chip select low for one guard delay, then ST_BIT_LOW.
- **ST_BIT_LOW**: clock low with the bit presented for one bit-delay. At the end it samples data-in and moves to ST_BIT_HIGH.
- **ST_BIT_HIGH**: clock high for one bit-delay. It then goes to ST_BIT_LOW for the next bit, or to ST_CS_HOLD after bit 24.
- **ST_CS_HOLD**: chip select still low for one guard delay, then ST_CS_GAP.
- **ST_CS_GAP**: chip select high for one guard delay. After the first frame it returns to ST_CS_SETUP for the second frame. After the second frame it goes to ST_IDLE and pulses completion.

Top module: `spi24_reg_master`

## Requirements
- R1: Every frame carries exactly 24 clock pulses, and its bits leave the data-out pin most significant bit first.
- R2: Each bit holds the clock low with the bit on data-out for `BIT_CLKS` cycles, then holds the clock high for `BIT_CLKS` cycles. Data-out stays unchanged across the whole bit. Data-in is sampled at the end of the low half. The clock is only ever low while chip select is low.
- R3: Chip select falls 2·`BIT_CLKS` cycles before the first clock fall. It rises 2·`BIT_CLKS` cycles after the end of the last high half, which is 3·`BIT_CLKS` cycles after the last clock rise. It then stays high for 2·`BIT_CLKS` cycles before the next frame or the end of the access.
- R4: A write sends the frame {0x70, 0x00, reg[7:0]} and then the frame {0x72, value[15:0]}.
- R5: A read sends the frame {0x70, 0x00, reg[7:0]} and then the frame {0x73, 0x0000}. The result is the last 16 bits sampled during the second frame, the first of these taken as bit 15.
- R6: Out of reset and whenever idle, chip select, clock and data-out are all high, cmd_ready is high and both completion pulses are low.
- R7: With `HAS_MISO` = 0 the read result is always 0x0000, whatever the data-in pin carries.
- R8: A request is taken only in a cycle where cmd_ready is high. cmd_ready stays low from the cycle after acceptance until the access completes, so a request offered during that time starts no frames.
- R9: Completion comes exactly 2·`BIT_CLKS` cycles after chip select rises at the end of the second frame. It is a single-cycle pulse: rsp_valid for a read, wr_done for a write, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Block idle and able to take a request |
| cmd_write | input | 1 | 1 = register write, 0 = register read |
| cmd_addr | input | 8 | Register number |
| cmd_wdata | input | 16 | Value to write |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | 16 | Read result, valid with rsp_valid |
| wr_done | output | 1 | One-cycle pulse: write finished |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the bridge |
| spi_miso | input | 1 | Serial data from the bridge (ignored if absent) |

## Verification
A state machine stuck in or skipping a state appears on the pins within one bit-delay or one guard delay. It shows as a clock half, setup, hold or gap of the wrong length, measured in system cycles against a model of the serial slave. A wrong bit counter or frame mux shows within the frame as a bit count other than 24 or a wrong frame word. A wrong phase flag shows as a third frame or a missing one. A capture fault shows at the completion pulse as read data that differs from the slave's register contents.

// File: rtl/spi24_pkg.sv
package spi24_pkg;

    localparam int unsigned FRAME_BITS = 24;
    localparam logic [7:0]  PFX_ADDR   = 8'h70;
    localparam logic [7:0]  PFX_WRITE  = 8'h72;
    localparam logic [7:0]  PFX_READ   = 8'h73;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CS_SETUP,
        ST_BIT_LOW,
        ST_BIT_HIGH,
        ST_CS_HOLD,
        ST_CS_GAP
    } spi24_state_e;

endpackage

// File: rtl/spi24_delay.sv
module spi24_delay #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len - CW'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign expired = (cnt == '0);

    AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (len != '0)); // R3

endmodule

// File: rtl/spi24_shifter.sv
module spi24_shifter #(
    parameter int unsigned FB       = 24,
    parameter bit          HAS_MISO = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FB-1:0] frame,
    input  logic          sample,
    input  logic          shift,
    input  logic          miso,
    output logic          mosi_bit,
    output logic          last_bit,
    output logic [FB-1:0] rx
);
    localparam int unsigned BW = $clog2(FB);

    logic [FB-1:0] tx_sr;
    logic [BW-1:0] bit_idx;
    logic          miso_eff;

    generate
        if (HAS_MISO) begin : g_miso
            assign miso_eff = miso;
        end else begin : g_nomiso
            assign miso_eff = 1'b0;
            AST_NO_MISO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                rx == '0); // R7
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr   <= '1;
            bit_idx <= '0;
            rx      <= '0;
        end else if (load) begin
            tx_sr   <= frame;
            bit_idx <= '0;
            rx      <= '0;
        end else begin
            if (sample) begin
                rx <= {rx[FB-2:0], miso_eff};
            end
            if (shift) begin
                tx_sr   <= {tx_sr[FB-2:0], 1'b1};
                bit_idx <= bit_idx + BW'(1);
            end
        end
    end

    assign mosi_bit = tx_sr[FB-1];
    assign last_bit = (bit_idx == BW'(FB - 1));

    AST_SHIFT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> (bit_idx <= BW'(FB - 1))); // R1

endmodule

// File: rtl/spi24_reg_master.sv
module spi24_reg_master
    import spi24_pkg::*;
#(
    parameter int unsigned BIT_CLKS = 4,
    parameter bit          HAS_MISO = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic        cmd_write,
    input  logic [7:0]  cmd_addr,
    input  logic [15:0] cmd_wdata,
    output logic        rsp_valid,
    output logic [15:0] rsp_rdata,
    output logic        wr_done,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int unsigned GUARD_CLKS = 2 * BIT_CLKS;
    localparam int unsigned CW         = $clog2(GUARD_CLKS + 1);

    spi24_state_e state, state_nx;

    logic                  expired, tmr_load;
    logic [CW-1:0]         tmr_len;
    logic                  phase;
    logic                  op_write;
    logic [7:0]            op_addr;
    logic [15:0]           op_wdata;
    logic                  accept, to_second, finish;
    logic                  sh_load, sh_sample, sh_shift, mosi_bit, last_bit;
    logic [FRAME_BITS-1:0] sh_frame, rx;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (cmd_valid) state_nx = ST_CS_SETUP;
            ST_CS_SETUP: if (expired)   state_nx = ST_BIT_LOW;
            ST_BIT_LOW:  if (expired)   state_nx = ST_BIT_HIGH;
            ST_BIT_HIGH: if (expired)   state_nx = last_bit ? ST_CS_HOLD : ST_BIT_LOW;
            ST_CS_HOLD:  if (expired)   state_nx = ST_CS_GAP;
            ST_CS_GAP:   if (expired)   state_nx = phase ? ST_IDLE : ST_CS_SETUP;
            default:                    state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign accept    = (state == ST_IDLE) && cmd_valid;
    assign to_second = (state == ST_CS_GAP) && expired && !phase;
    assign finish    = (state == ST_CS_GAP) && expired && phase;
    assign tmr_load  = (state_nx != state);
    assign tmr_len   = (state_nx == ST_BIT_LOW || state_nx == ST_BIT_HIGH)
                       ? CW'(BIT_CLKS) : CW'(GUARD_CLKS);

    spi24_delay #(.CW(CW)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .len     (tmr_len),
        .expired (expired)
    );

    // request latch and frame phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= 1'b0;
            op_write <= 1'b0;
            op_addr  <= '0;
            op_wdata <= '0;
        end else if (accept) begin
            phase    <= 1'b0;
            op_write <= cmd_write;
            op_addr  <= cmd_addr;
            op_wdata <= cmd_wdata;
        end else if (to_second) begin
            phase    <= 1'b1;
        end
    end

    assign sh_load   = accept || to_second;
    assign sh_frame  = accept   ? {PFX_ADDR, 8'h00, cmd_addr} :
                       op_write ? {PFX_WRITE, op_wdata} :
                                  {PFX_READ, 16'h0000};
    assign sh_sample = (state == ST_BIT_LOW)  && expired;
    assign sh_shift  = (state == ST_BIT_HIGH) && expired;

    spi24_shifter #(.FB(FRAME_BITS), .HAS_MISO(HAS_MISO)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .frame    (sh_frame),
        .sample   (sh_sample),
        .shift    (sh_shift),
        .miso     (spi_miso),
        .mosi_bit (mosi_bit),
        .last_bit (last_bit),
        .rx       (rx)
    );

    // completion pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            wr_done   <= 1'b0;
        end else begin
            rsp_valid <= finish && !op_write;
            wr_done   <= finish && op_write;
        end
    end

    // pin outputs
    always_comb begin
        cmd_ready = (state == ST_IDLE);
        spi_cs_n  = (state == ST_IDLE) || (state == ST_CS_GAP);
        spi_sck   = (state != ST_BIT_LOW);
        spi_mosi  = (state == ST_BIT_LOW || state == ST_BIT_HIGH) ? mosi_bit : 1'b1;
        rsp_rdata = rx[15:0];
    end

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready); // R8
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && wr_done)); // R9
    AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || wr_done) |=> !(rsp_valid || wr_done)); // R9
    AST_SCK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_sck |-> !spi_cs_n); // R2
    AST_CS_RISE_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> ($past(state) == ST_CS_HOLD)); // R3
    AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sck) |-> $stable(spi_mosi)); // R2

endmodule

// File: tb/spi24_reg_master_test.sv
module spi24_reg_master_test;
    localparam int B = 4;
    localparam int G = 2 * B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [7:0]  cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic        cmd_ready, rsp_valid, wr_done, spi_cs_n, spi_sck, spi_mosi;
    logic [15:0] rsp_rdata;
    logic        spi_miso = 1'b1;
    logic        nm_ready, nm_rsp_valid, nm_wr_done, nm_cs_n, nm_sck, nm_mosi;
    logic [15:0] nm_rdata;

    always #5 clk = ~clk;

    spi24_reg_master #(.BIT_CLKS(B), .HAS_MISO(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wr_done(wr_done),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

    spi24_reg_master #(.BIT_CLKS(B), .HAS_MISO(1'b0)) uut_nomiso (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(nm_ready),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(nm_rsp_valid), .rsp_rdata(nm_rdata), .wr_done(nm_wr_done),
        .spi_cs_n(nm_cs_n), .spi_sck(nm_sck), .spi_mosi(nm_mosi), .spi_miso(spi_miso));

    int errors = 0;
    int checks = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // behavioural slave and pin monitor, sampled on the falling clock edge
    logic [15:0] mem [256];
    logic [23:0] frames [64];
    int          fbits  [64];
    int          nfr = 0;
    int          cyc = 0;
    logic        p_cs = 1'b1, p_sck = 1'b1;
    logic [23:0] sr, resp;
    int          nb = 0;
    int          t_csfall, t_csrise, t_fall, t_rise, t_done;
    bit          first_fall;
    logic [7:0]  s_addr = '0;
    logic        bit_val;
    int          tim_err = 0, tim_act = 0, tim_exp = 0;
    int          pulses = 0, wide = 0;
    logic        p_pulse = 1'b0;
    logic [15:0] got_rd, got_nm;
    bit          got_rd_v, got_wr_v;

    task automatic tim(input int act, input int exp);
        if (act != exp) begin
            tim_err++;
            tim_act = act;
            tim_exp = exp;
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (p_cs && !spi_cs_n) begin
            t_csfall   = cyc;
            sr         = '0;
            nb         = 0;
            first_fall = 1'b1;
            if (nfr % 2 == 1) tim(cyc - t_csrise, G);  // R3 gap between frames
            resp       = {8'h00, mem[s_addr]};
            spi_miso   = resp[23];
        end
        if (!spi_cs_n && p_sck && !spi_sck) begin
            if (first_fall) tim(cyc - t_csfall, G);   // R3 setup
            else            tim(cyc - t_rise, B);     // R2 high half
            first_fall = 1'b0;
            t_fall     = cyc;
            bit_val    = spi_mosi;
        end
        if (!spi_cs_n && !p_sck && spi_sck) begin
            tim(cyc - t_fall, B);                     // R2 low half
            if (spi_mosi != bit_val) tim(1, 0);       // R2 mosi stable
            sr     = {sr[22:0], spi_mosi};
            nb++;
            t_rise = cyc;
            if (nb < 24) spi_miso = resp[23 - nb];
        end
        if (spi_cs_n && !spi_sck) tim(2, 0);          // R2 sck low outside cs
        if (!p_cs && spi_cs_n) begin
            tim(cyc - t_rise, B + G);                 // R3 hold
            frames[nfr % 64] = sr;
            fbits[nfr % 64]  = nb;
            nfr++;
            t_csrise = cyc;
            spi_miso = 1'b1;
            if (sr[23:16] == 8'h70) s_addr = sr[7:0];
            if (sr[23:16] == 8'h72) mem[s_addr] = sr[15:0];
        end
        if (rsp_valid || wr_done) begin
            if (p_pulse) wide++;
            if (rsp_valid && wr_done) wide++;
            pulses++;
            t_done   = cyc;
            got_rd   = rsp_rdata;
            got_rd_v = rsp_valid;
            got_wr_v = wr_done;
            got_nm   = nm_rdata;
        end
        p_pulse = rsp_valid || wr_done;
        p_cs    = spi_cs_n;
        p_sck   = spi_sck;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic access(input bit wr, input logic [7:0] a, input logic [15:0] d);
        int p0, f0;
        while (!cmd_ready) @(negedge clk);
        p0 = pulses;
        f0 = nfr;
        cmd_write = wr; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (pulses == p0) @(negedge clk);
        check(nfr - f0 == 2, "R8 frames per access", nfr - f0, 2);
        check(fbits[f0 % 64] == 24 && fbits[(f0 + 1) % 64] == 24, "R1 bits per frame",
              fbits[(f0 + 1) % 64], 24);
        check(frames[f0 % 64] == {16'h7000, a}, "R1 R4 R5 address frame",
              frames[f0 % 64], {16'h7000, a});
        check(t_done - t_csrise == G, "R9 completion delay", t_done - t_csrise, G);
        check(got_rd_v == !wr && got_wr_v == wr, "R9 pulse kind",
              {got_rd_v, got_wr_v}, {!wr, wr});
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(spi_cs_n && spi_sck && spi_mosi, "R6 reset pins",
              {spi_cs_n, spi_sck, spi_mosi}, 3'b111);
        check(cmd_ready && !rsp_valid && !wr_done, "R6 reset handshake",
              {cmd_ready, rsp_valid, wr_done}, 3'b100);
    endtask

    task automatic t_write(input logic [7:0] a, input logic [15:0] d);
        access(1'b1, a, d);
        check(frames[(nfr - 1) % 64] == {8'h72, d}, "R4 write data frame",
              frames[(nfr - 1) % 64], {8'h72, d});
        check(mem[a] == d, "R4 slave register updated", mem[a], d);
    endtask

    task automatic t_read(input logic [7:0] a);
        logic [15:0] e;
        e = mem[a];
        access(1'b0, a, 16'hDEAD);
        check(frames[(nfr - 1) % 64] == 24'h730000, "R5 read data frame",
              frames[(nfr - 1) % 64], 24'h730000);
        check(got_rd == e, "R5 read result", got_rd, e);
        check(got_nm == 16'h0000, "R7 absent data-in reads zero", got_nm, 0);
    endtask

    task automatic t_busy();
        int f0;
        while (!cmd_ready) @(negedge clk);
        f0 = nfr;
        cmd_write = 1'b1; cmd_addr = 8'h11; cmd_wdata = 16'h1111; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_addr = 8'h22; cmd_wdata = 16'h2222;
        repeat (20) @(negedge clk);
        check(!cmd_ready, "R8 ready low while busy", cmd_ready, 0);
        cmd_valid = 1'b0;
        while (!cmd_ready) @(negedge clk);
        repeat (3 * G) @(negedge clk);
        check(nfr - f0 == 2, "R8 busy request ignored", nfr - f0, 2);
        check(mem[8'h11] == 16'h1111 && mem[8'h22] == 16'h0000, "R8 only first request done",
              mem[8'h22], 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101);
        mem[8'h22] = 16'h0000;
        t_reset();
        t_write(8'h00, 16'hA55A);
        t_write(8'hFF, 16'hFFFF);
        t_write(8'h3C, 16'h0000);
        t_read(8'h00);
        t_read(8'hFF);
        t_read(8'h81);
        t_read(8'h3C);
        t_busy();
        t_read(8'h11);
        check(spi_cs_n && spi_sck && spi_mosi && cmd_ready, "R6 idle pins",
              {spi_cs_n, spi_sck, spi_mosi, cmd_ready}, 4'hF);
        check(tim_err == 0, "R2 R3 pin timing", tim_act, tim_exp);
        check(wide == 0, "R9 single-cycle pulse", wide, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule